// File: doc/BRIEF.md
# Periodic Battery Test Scheduler

This block sequences load tests on a backup cell. When the supply is good, it periodically raises a strobe that applies a test load to the battery. In the last cycle of that strobe it reads a comparator that reports whether the loaded battery sits below its threshold. A failed test sets an active-low warning flag that stays set. While the flag is set, tests run on a shorter period so that a swapped cell is noticed quickly. A passing test clears the flag only after the battery has been seen absent for long enough to count as a real replacement. After that, the long period resumes.

The block also holds a factory seal. From reset, backup power stays blocked until the supply has been valid once. A fresh cell can then sit in a stored unit without being drained. Losing the supply abandons any test in progress and keeps the warning as it was. Every return of the supply starts a new test after a recovery delay. All intervals are tick-count parameters.

Top module: `batt_test_sched`

## Requirements
- R1: `backup_en` is 0 from reset until `supply_ok` is first sampled high. It is 1 from the next cycle on and stays 1 through later supply losses until reset.
- R2: When `supply_ok` is sampled high at a clock edge after reset or after being low, `load_en` stays low for exactly REC_TICKS cycles after that edge and then rises.
- R3: Every test strobe that is not interrupted keeps `load_en` high for exactly PULSE_TICKS cycles.
- R4: While the warning is inactive, `load_en` stays low for exactly NORM_TICKS cycles between the end of one strobe and the start of the next.
- R5: While the warning is active, that low gap is exactly WARN_TICKS cycles.
- R6: `batt_low` is sampled only in the last cycle of a strobe. A 1 there drives `warn_n` to 0 in the same cycle that `load_en` falls. A 1 at any other time has no effect.
- R7: A passing test (`batt_low` = 0 in the last strobe cycle) leaves an active warning set if no qualifying detach has occurred since the previous strobe ended.
- R8: A qualifying detach is `batt_present` low for at least DETACH_TICKS consecutive cycles. After one, the next passing test sets `warn_n` to 1 and the normal gap resumes. A shorter detach has no effect.
- R9: When `supply_ok` is sampled low, `load_en` is low from the next cycle on and no test runs while the supply is out. A strobe cut short records no result, and `warn_n` keeps its value.
- R10: A test is always performed after each supply return, including when the warning is active, and the warning then follows R6 to R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all intervals count its cycles |
| rst | input | 1 | Synchronous reset, active high |
| supply_ok | input | 1 | Main supply is within tolerance |
| batt_present | input | 1 | A battery is attached |
| batt_low | input | 1 | Comparator: loaded battery below threshold |
| load_en | output | 1 | Applies the test load while high |
| warn_n | output | 1 | Battery warning, active low, latched |
| backup_en | output | 1 | Battery may back up the memory supply (seal released) |

## Verification
The checker assumes that `supply_ok`, `batt_present` and `batt_low` are synchronous to `clk` and hold stable around each edge. It also assumes every tick parameter is at least 1, so that no interval collapses to zero. The bench keeps to these assumptions by changing inputs only on falling edges. It uses small tick values so that each gap can be counted cycle by cycle. Detach pulses are placed inside the wait gap, well clear of the strobe, so that each one is judged only by its length.

// File: rtl/bts_pkg.sv
package bts_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_REC   = 2'd1,
    ST_PULSE = 2'd2,
    ST_WAIT  = 2'd3
  } bts_state_e;
endpackage

// File: rtl/bts_interval_timer.sv
module bts_interval_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/bts_detach_mon.sv
module bts_detach_mon #(
  parameter int DETACH_TICKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic batt_present,
  input  logic consume,
  output logic qualified
);
  localparam int DW = $clog2(DETACH_TICKS + 1);
  localparam logic [DW-1:0] LAST = DW'(DETACH_TICKS - 1);
  localparam logic [DW-1:0] SAT  = DW'(DETACH_TICKS);

  logic [DW-1:0] run_q;
  logic          hit;

  assign hit = !batt_present && (run_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)               run_q <= '0;
    else if (batt_present) run_q <= '0;
    else if (run_q != SAT) run_q <= run_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)          qualified <= 1'b0;
    else if (hit)     qualified <= 1'b1;
    else if (consume) qualified <= 1'b0;
  end
endmodule

// File: rtl/bts_seal.sv
module bts_seal (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  output logic backup_en
);
  always_ff @(posedge clk) begin
    if (rst)            backup_en <= 1'b0;
    else if (supply_ok) backup_en <= 1'b1;
  end
endmodule

// File: rtl/batt_test_sched.sv
module batt_test_sched #(
  parameter int NORM_TICKS   = 86_400_000,
  parameter int WARN_TICKS   = 5_000,
  parameter int PULSE_TICKS  = 1_000,
  parameter int REC_TICKS    = 125,
  parameter int DETACH_TICKS = 1_000
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  input  logic batt_present,
  input  logic batt_low,
  output logic load_en,
  output logic warn_n,
  output logic backup_en
);
  import bts_pkg::*;

  localparam int M1   = (NORM_TICKS > WARN_TICKS) ? NORM_TICKS : WARN_TICKS;
  localparam int M2   = (PULSE_TICKS > REC_TICKS) ? PULSE_TICKS : REC_TICKS;
  localparam int MAXT = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXT + 1);

  localparam logic [CW-1:0] REC_LD   = CW'(REC_TICKS - 1);
  localparam logic [CW-1:0] PULSE_LD = CW'(PULSE_TICKS - 1);
  localparam logic [CW-1:0] NORM_LD  = CW'(NORM_TICKS - 1);
  localparam logic [CW-1:0] WARN_LD  = CW'(WARN_TICKS - 1);

  bts_state_e    state_q;
  logic          expired;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          pulse_end;
  logic          detach_ok;
  logic          warn_nxt;

  assign pulse_end = supply_ok && (state_q == ST_PULSE) && expired;
  // a fail always latches; a pass clears only after a qualifying swap
  assign warn_nxt  = batt_low ? 1'b0 : (warn_n ? 1'b1 : detach_ok);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = PULSE_LD;
    if (supply_ok) begin
      unique case (state_q)
        ST_OFF: begin
          tmr_load = 1'b1;
          tmr_val  = REC_LD;
        end
        ST_REC, ST_WAIT: tmr_load = expired;
        ST_PULSE: begin
          tmr_load = expired;
          tmr_val  = warn_nxt ? NORM_LD : WARN_LD;
        end
        default: tmr_load = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OFF;
      load_en <= 1'b0;
      warn_n  <= 1'b1;
    end else if (!supply_ok) begin
      state_q <= ST_OFF;
      load_en <= 1'b0;
    end else begin
      unique case (state_q)
        ST_OFF: state_q <= ST_REC;
        ST_REC, ST_WAIT:
          if (expired) begin
            state_q <= ST_PULSE;
            load_en <= 1'b1;
          end
        ST_PULSE:
          if (expired) begin
            state_q <= ST_WAIT;
            load_en <= 1'b0;
            warn_n  <= warn_nxt;
          end
        default: state_q <= ST_OFF;
      endcase
    end
  end

  bts_interval_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (expired)
  );

  bts_detach_mon #(.DETACH_TICKS(DETACH_TICKS)) u_detach (
    .clk          (clk),
    .rst          (rst),
    .batt_present (batt_present),
    .consume      (pulse_end),
    .qualified    (detach_ok)
  );

  bts_seal u_seal (
    .clk       (clk),
    .rst       (rst),
    .supply_ok (supply_ok),
    .backup_en (backup_en)
  );
endmodule

// File: rtl/bts_sched_chk.sv
module bts_sched_chk #(
  parameter int PULSE_TICKS = 1_000
) (
  input logic clk,
  input logic rst,
  input logic supply_ok,
  input logic load_en,
  input logic warn_n,
  input logic backup_en
);
  localparam int HW = $clog2(PULSE_TICKS + 2);
  localparam logic [HW-1:0] HSAT = HW'(PULSE_TICKS + 1);

  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)                           hi_cnt <= '0;
    else if (!load_en)                 hi_cnt <= '0;
    else if (hi_cnt != HSAT)           hi_cnt <= hi_cnt + 1'b1;
  end

  // R9
  load_off_when_supply_lost_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(supply_ok) |-> !load_en);

  // R6
  warn_set_only_at_strobe_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(warn_n) |-> $fell(load_en));

  // R8
  warn_clear_only_at_strobe_end_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(warn_n) |-> $fell(load_en));

  // R1
  seal_never_recloses_chk: assert property (@(posedge clk) disable iff (rst)
    !$fell(backup_en));

  // R1
  seal_opens_after_supply_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(backup_en) |-> $past(supply_ok));

  // R3
  strobe_not_too_long_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |-> (hi_cnt < HW'(PULSE_TICKS)));
endmodule

bind batt_test_sched bts_sched_chk #(.PULSE_TICKS(PULSE_TICKS)) u_sched_chk (
  .clk       (clk),
  .rst       (rst),
  .supply_ok (supply_ok),
  .load_en   (load_en),
  .warn_n    (warn_n),
  .backup_en (backup_en)
);

// File: tb/test_batt_test_sched.sv
`timescale 1ns/1ps
module test_batt_test_sched;
  localparam int NT = 60;
  localparam int WT = 20;
  localparam int PT = 4;
  localparam int RT = 10;
  localparam int DT = 8;

  logic clk = 1'b0;
  logic rst, supply_ok, batt_present, batt_low;
  logic load_en, warn_n, backup_en;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  batt_test_sched #(
    .NORM_TICKS(NT), .WARN_TICKS(WT), .PULSE_TICKS(PT),
    .REC_TICKS(RT), .DETACH_TICKS(DT)
  ) i_batt_test_sched (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .batt_present(batt_present),
    .batt_low(batt_low), .load_en(load_en), .warn_n(warn_n), .backup_en(backup_en)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // counts high samples from the current falling edge; ends on the first low one
  task automatic measure_high(output int n);
    n = 0;
    while (load_en && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  // counts low samples from the current falling edge; ends on the first high one
  task automatic measure_low(output int n);
    n = 0;
    while (!load_en && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; supply_ok = 1'b0; batt_present = 1'b1; batt_low = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check("R1", "backup before supply", int'(backup_en), 0);
    check("R9", "load_en without supply", int'(load_en), 0);
    check("R6", "warn_n after reset", int'(warn_n), 1);
  endtask

  task automatic t_powerup();
    int n;
    supply_ok = 1'b1;
    @(negedge clk);
    check("R1", "backup after supply", int'(backup_en), 1);
    measure_low(n);
    check("R2", "recovery delay", n, RT);
  endtask

  task automatic t_pass_with_glitch();
    int n;
    measure_high(n);
    check("R3", "strobe length", n, PT);
    check("R6", "warn_n after pass", int'(warn_n), 1);
    batt_low = 1'b1;
    repeat (10) @(negedge clk);
    batt_low = 1'b0;
    measure_low(n);
    check("R4", "normal gap", n + 10, NT);
    measure_high(n);
    check("R6", "comparator outside strobe ignored", int'(warn_n), 1);
    measure_low(n);
    check("R4", "normal gap again", n, NT);
  endtask

  task automatic t_fail();
    int n;
    batt_low = 1'b1;
    measure_high(n);
    check("R3", "strobe length on fail", n, PT);
    check("R6", "warn_n after fail", int'(warn_n), 0);
    batt_low = 1'b0;
    measure_low(n);
    check("R5", "warning gap", n, WT);
  endtask

  task automatic t_pass_no_detach();
    int n;
    measure_high(n);
    check("R7", "warning kept without swap", int'(warn_n), 0);
    measure_low(n);
    check("R5", "warning gap kept", n, WT);
  endtask

  task automatic t_detach(input int len, input int exp_warn, input int exp_gap, input string req);
    int n;
    measure_high(n);
    batt_present = 1'b0;
    repeat (len) @(negedge clk);
    batt_present = 1'b1;
    measure_low(n);
    check("R5", "gap around detach", n + len, WT);
    measure_high(n);
    check(req, "warn_n after detach and pass", int'(warn_n), exp_warn);
    measure_low(n);
    check(req, "gap after detach test", n, exp_gap);
  endtask

  task automatic t_drop_mid_strobe();
    int n;
    batt_low = 1'b1;
    @(negedge clk);
    supply_ok = 1'b0;
    @(negedge clk);
    check("R9", "strobe cut on supply loss", int'(load_en), 0);
    n = 0;
    repeat (20) begin
      @(negedge clk);
      if (load_en) n++;
    end
    check("R9", "no strobe while supply out", n, 0);
    check("R9", "cut strobe records nothing", int'(warn_n), 1);
    check("R1", "seal stays open", int'(backup_en), 1);
    supply_ok = 1'b1;
    @(negedge clk);
    measure_low(n);
    check("R2", "recovery after return", n, RT);
    batt_low = 1'b0;
    measure_high(n);
    check("R3", "strobe after return", n, PT);
    measure_low(n);
    check("R4", "normal gap after return", n, NT);
  endtask

  task automatic t_outage_with_warning();
    int n;
    batt_low = 1'b1;
    measure_high(n);
    check("R6", "warn_n after second fail", int'(warn_n), 0);
    batt_low = 1'b0;
    supply_ok = 1'b0;
    n = 0;
    repeat (100) begin
      @(negedge clk);
      if (load_en) n++;
    end
    check("R9", "no test during outage", n, 0);
    check("R9", "warning held in outage", int'(warn_n), 0);
    supply_ok = 1'b1;
    @(negedge clk);
    measure_low(n);
    check("R10", "retest delay with warning", n, RT);
    measure_high(n);
    check("R10", "retest strobe with warning", n, PT);
    check("R7", "warning kept after power-up pass", int'(warn_n), 0);
    measure_low(n);
    check("R5", "warning gap after power-up", n, WT);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_powerup();
    t_pass_with_glitch();
    t_fail();
    t_pass_no_detach();
    t_detach(DT - 1, 0, WT, "R8");
    t_detach(DT, 1, NT, "R8");
    t_drop_mid_strobe();
    t_outage_with_warning();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule